// File: doc/BRIEF.md
# IN token order log

This block keeps a running record of the endpoint numbers carried by IN tokens that a USB device controller accepts, in the order they arrive. Each token occupies one 4-bit slot of a small circular store. A write pointer names the slot that the next token will fill. Once every slot has been used, the pointer returns to slot 0 and later tokens replace the oldest ones. A push is never refused.

A sticky wrap flag records that the pointer has returned to slot 0 at least once. Software reads a single 32-bit word that holds:

- the first six physical slots,
- the wrap flag,
- the current write pointer.

From these values software can rebuild the arrival order. A synchronous clear empties the store and resets the pointer and the flag. The endpoint token decoder feeds the token strobe and the endpoint number. The register file samples the read word.

Top module: `tkn_seq_learn_q`

## Requirements
- R1: After reset, every bit of `rd_word` is 0.
- R2: When `tok_vld` is 1 and `q_clr` is 0 at a rising edge, `tok_ep` is stored in the slot named by the write pointer. The pointer then advances by one modulo DEPTH, and both changes are visible on `rd_word` after that edge.
- R3: When all DEPTH slots hold tokens, a further token is still accepted and overwrites the slot the pointer names, which is the oldest one.
- R4: Slot k, for k from 0 to 5, appears at `rd_word[8+4k +: 4]`. Slot 0 is at bits [11:8] and slot 5 is at bits [31:28]. A slot at or beyond DEPTH reads as 0.
- R5: Bit 7 of `rd_word` (the wrap flag) becomes 1 after a token is accepted while the pointer equals DEPTH-1.
- R6: Once the wrap flag is 1, it stays 1 through any number of further tokens or idle cycles, until a clear.
- R7: When `q_clr` is 1 at a rising edge, all slots, the pointer and the wrap flag become 0.
- R8: When `q_clr` and `tok_vld` are both 1 in the same cycle, the clear wins. The token is dropped and `rd_word` is 0 afterwards.
- R9: The write pointer appears at `rd_word[PTR_W-1:0]`, which is bits [2:0] for the default depth of 8. Bits [6:PTR_W] always read as 0.
- R10: A cycle with neither a token nor a clear leaves `rd_word` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_vld | input | 1 | One-cycle strobe: an IN token was accepted |
| tok_ep | input | 4 | Endpoint number of the token |
| q_clr | input | 1 | Synchronous clear of the whole store |
| rd_word | output | 32 | Read-only status word: six slots, wrap flag and write pointer |

## Verification
A clear and a token strobe can arrive in the same cycle, and the clear has to suppress both the slot write and the pointer step. The bench provokes this collision once at each of the eight pointer positions, both before and after the first wrap. Each time it requires the read word to be exactly 0 on the following cycle. A later push must then land in slot 0 with the wrap flag still 0.

// File: rtl/tknq_pkg.sv
package tknq_pkg;
  localparam int EP_W        = 4;   // endpoint number width
  localparam int WORD_W      = 32;  // read word width
  localparam int SHOWN_SLOTS = 6;   // slots visible in the read word
  localparam int SLOT_LSB    = 8;   // bit position of slot 0
  localparam int WRAP_POS    = 7;   // bit position of the wrap flag

  // pointer step modulo depth
  function automatic int ptr_step(input int p, input int depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

  // true when a push at pointer p makes the pointer roll over
  function automatic bit rolls_over(input int p, input int depth);
    return p == depth - 1;
  endfunction

  // bit position of a shown slot inside the read word
  function automatic int slot_pos(input int k);
    return SLOT_LSB + EP_W * k;
  endfunction
endpackage

// File: rtl/tknq_ptr.sv
module tknq_ptr #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             clr,
  output logic [PTR_W-1:0] wr_ptr,
  output logic             wrap_flag,
  output logic             wrap_evt
);
  logic [PTR_W-1:0] ptr_nxt;

  always_comb begin
    ptr_nxt  = PTR_W'(tknq_pkg::ptr_step(int'(wr_ptr), DEPTH));
    wrap_evt = push && tknq_pkg::rolls_over(int'(wr_ptr), DEPTH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      wrap_flag <= 1'b0;
    end else if (clr) begin
      wr_ptr    <= '0;
      wrap_flag <= 1'b0;
    end else if (push) begin
      wr_ptr <= ptr_nxt;
      if (wrap_evt) wrap_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/tknq_slots.sv
module tknq_slots #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int EP_W  = tknq_pkg::EP_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  push,
  input  logic                  clr,
  input  logic [PTR_W-1:0]      wr_ptr,
  input  logic [EP_W-1:0]       ep,
  output logic [DEPTH*EP_W-1:0] slots
);
  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic hit;
    assign hit = push && (wr_ptr == PTR_W'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   slots[s*EP_W +: EP_W] <= '0;
      else if (clr) slots[s*EP_W +: EP_W] <= '0;
      else if (hit) slots[s*EP_W +: EP_W] <= ep;
    end
  end
endmodule

// File: rtl/tknq_pack.sv
module tknq_pack #(
  parameter int DEPTH = 8,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int EP_W   = tknq_pkg::EP_W,
  localparam int WORD_W = tknq_pkg::WORD_W,
  localparam int SHOWN  = tknq_pkg::SHOWN_SLOTS
) (
  input  logic [DEPTH*EP_W-1:0] slots,
  input  logic [PTR_W-1:0]      wr_ptr,
  input  logic                  wrap_flag,
  output logic [WORD_W-1:0]     word
);
  logic [EP_W-1:0] shown [SHOWN];

  for (genvar k = 0; k < SHOWN; k++) begin : g_field
    if (k < DEPTH) begin : g_real
      assign shown[k] = slots[k*EP_W +: EP_W];
    end else begin : g_none
      assign shown[k] = '0;
    end
  end

  always_comb begin
    word = '0;
    word[PTR_W-1:0] = wr_ptr;
    word[tknq_pkg::WRAP_POS] = wrap_flag;
    for (int k = 0; k < SHOWN; k++)
      word[tknq_pkg::slot_pos(k) +: EP_W] = shown[k];
  end
endmodule

// File: rtl/tkn_seq_learn_q.sv
module tkn_seq_learn_q #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int EP_W  = tknq_pkg::EP_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tok_vld,
  input  logic [EP_W-1:0] tok_ep,
  input  logic            q_clr,
  output logic [31:0]     rd_word
);
  logic                  push;
  logic                  wrap_evt;
  logic                  wrap_flag;
  logic [PTR_W-1:0]      wr_ptr;
  logic [DEPTH*EP_W-1:0] slots;

  // clear takes priority over a token in the same cycle
  assign push = tok_vld && !q_clr;

  tknq_ptr #(.DEPTH(DEPTH)) ptr_i (
    .clk(clk), .rst_n(rst_n), .push(push), .clr(q_clr),
    .wr_ptr(wr_ptr), .wrap_flag(wrap_flag), .wrap_evt(wrap_evt)
  );

  tknq_slots #(.DEPTH(DEPTH)) slots_i (
    .clk(clk), .rst_n(rst_n), .push(push), .clr(q_clr),
    .wr_ptr(wr_ptr), .ep(tok_ep), .slots(slots)
  );

  tknq_pack #(.DEPTH(DEPTH)) pack_i (
    .slots(slots), .wr_ptr(wr_ptr), .wrap_flag(wrap_flag), .word(rd_word)
  );
endmodule

// File: rtl/tkn_seq_learn_q_chk.sv
module tkn_seq_learn_q_chk #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int EP_W  = tknq_pkg::EP_W
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  tok_vld,
  input logic [EP_W-1:0]       tok_ep,
  input logic                  q_clr,
  input logic                  push,
  input logic                  wrap_evt,
  input logic [PTR_W-1:0]      wr_ptr,
  input logic                  wrap_flag,
  input logic [DEPTH*EP_W-1:0] slots,
  input logic [31:0]           rd_word
);
  localparam logic [31:0] LOW_MASK  = 32'h7F;
  localparam logic [31:0] PTR_MASK  = (32'h1 << PTR_W) - 32'h1;
  localparam logic [31:0] SPARE_MASK = LOW_MASK & ~PTR_MASK;

  function automatic logic [EP_W-1:0] pick(input logic [DEPTH*EP_W-1:0] s, input int i);
    return s[i*EP_W +: EP_W];
  endfunction

  assert_ptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_vld && !q_clr) |=> int'(wr_ptr) == tknq_pkg::ptr_step(int'($past(wr_ptr)), DEPTH));

  assert_slot_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> pick(slots, int'($past(wr_ptr))) == $past(tok_ep));

  assert_wrap_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_vld && !q_clr && int'(wr_ptr) == DEPTH - 1) |=> rd_word[7]);

  assert_wrap_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_flag && !q_clr) |=> wrap_flag);

  assert_wrap_only_on_roll_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap_flag && !wrap_evt) |=> !wrap_flag);

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    q_clr |=> rd_word == 32'h0);

  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (q_clr && tok_vld) |=> (wr_ptr == '0 && !wrap_flag));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tok_vld && !q_clr) |=> $stable(rd_word));

  assert_spare_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_word & SPARE_MASK) == 32'h0);
endmodule

bind tkn_seq_learn_q tkn_seq_learn_q_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .tok_vld(tok_vld), .tok_ep(tok_ep), .q_clr(q_clr),
  .push(push), .wrap_evt(wrap_evt), .wr_ptr(wr_ptr), .wrap_flag(wrap_flag),
  .slots(slots), .rd_word(rd_word)
);

// File: tb/tkn_seq_learn_q_tb.sv
module tkn_seq_learn_q_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int D = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tok_vld = 1'b0;
  logic [3:0]  tok_ep = 4'h0;
  logic        q_clr = 1'b0;
  logic [31:0] rd_word;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  int m_slot [D];
  int m_ptr;
  bit m_wrap;

  tkn_seq_learn_q #(.DEPTH(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .tok_vld(tok_vld), .tok_ep(tok_ep),
    .q_clr(q_clr), .rd_word(rd_word)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // expected read word: pointer in low bits, flag at 7, slot k at 8+4k
  function automatic logic [31:0] exp_word();
    logic [31:0] w = 32'(m_ptr);
    if (m_wrap) w = w + 32'd128;
    for (int k = 0; k < 6; k++) w = w + (32'(m_slot[k]) << (8 + 4*k));
    return w;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < D; i++) m_slot[i] = 0;
    m_ptr = 0;
    m_wrap = 0;
  endtask

  // called at a negedge; returns at the following negedge
  task automatic cyc(input bit v, input int ep, input bit c);
    tok_vld = v; tok_ep = 4'(ep); q_clr = c;
    @(posedge clk);
    if (c) model_clear();
    else if (v) begin
      m_slot[m_ptr] = ep;
      if (m_ptr == D - 1) m_wrap = 1;
      m_ptr = (m_ptr + 1) % D;
    end
    @(negedge clk);
    tok_vld = 0; q_clr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    check("R1 reset word", rd_word, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", rd_word, 32'h0);

    // fill one round and beyond: R2 store/step, R4 placement, R9 pointer bits
    for (int i = 0; i < 3*D; i++) begin
      cyc(1, (i * 7 + 3) % 16, 0);
      check($sformatf("R2 R4 R9 push %0d", i), rd_word, exp_word());
      if (i == D - 2) check("R5 no wrap before roll", {31'h0, rd_word[7]}, 32'h0);
      if (i == D - 1) check("R5 wrap on roll", {31'h0, rd_word[7]}, 32'h1);
      if (i >= D) check($sformatf("R3 overwrite slot %0d", i % D), rd_word, exp_word());
    end

    // idle cycles hold everything; wrap stays set
    for (int i = 0; i < 5; i++) begin
      cyc(0, 15, 0);
      check("R10 idle hold", rd_word, exp_word());
      check("R6 wrap sticky idle", {31'h0, rd_word[7]}, 32'h1);
    end

    // clear
    cyc(0, 0, 1);
    check("R7 clear", rd_word, 32'h0);

    // every endpoint value into each visible slot position
    for (int ep = 0; ep < 16; ep++) begin
      cyc(1, ep, 0);
      check($sformatf("R4 ep %0d", ep), rd_word, exp_word());
    end
    check("R6 wrap after 2 rounds", {31'h0, rd_word[7]}, 32'h1);

    // clear and token collide at each pointer position, pre and post wrap
    for (int pass = 0; pass < 2; pass++) begin
      for (int p = 0; p < D; p++) begin
        cyc(0, 0, 1);
        for (int j = 0; j < p + pass * D; j++) cyc(1, (j + p) % 16, 0);
        cyc(1, 9, 1);
        check($sformatf("R8 clear wins ptr %0d pass %0d", p, pass), rd_word, 32'h0);
        cyc(1, 5, 0);
        check("R8 next push lands slot 0", rd_word, exp_word());
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule